// File: doc/BRIEF.md
# Extended Virtual Address Segment Classifier

This block sorts a 64-bit virtual address into one of the extended address segments of a 64-bit core: user mapped space, supervisor mapped space, the unmapped kernel physical window, kernel mapped space, or the compatibility region at the top of the map. For each address it reports the segment, whether the request has to go on to the translation lookaside buffer ("mapped"), and whether the address is illegal for the current enables ("bad"). In the physical window it also returns the physical address and grants read and write access.

The upper end of each mapped segment is not fixed. It comes from a segment mask built from the `SEG_BITS` parameter, which is the implemented virtual width. One netlist therefore serves cores with 40-bit or 42-bit virtual spaces, and 32 for narrow cores. Three enables, one each for the user, supervisor and kernel extended spaces, gate the segments. The `REG_OUT` parameter picks between a purely combinational verdict and a verdict held in one output register.

The block has no state machine. Its only state is the optional output register. That register has two conditions: in reset it holds the compatibility verdict with every flag clear, and out of reset it follows the classifier once per clock.

Top module: `vaseg_classifier`

## Requirements
- R1: The segment mask M has bits 63:62 and bits SEG_BITS-1:0 set and all other bits clear. An address below 0x3FFF_FFFF_FFFF_FFFF gets segment code 0 (user). It is mapped if the user enable is set and the address is below (0x3FFF_FFFF_FFFF_FFFF & M). In every other case it is bad.
- R2: Any other address below 0x7FFF_FFFF_FFFF_FFFF gets code 1 (supervisor). It is mapped if the supervisor enable is set and the address is below (0x7FFF_FFFF_FFFF_FFFF & M). In every other case it is bad.
- R3: Any other address below 0xBFFF_FFFF_FFFF_FFFF gets code 2 (physical window). It is legal if the kernel enable is set and address bits 58:0 are below 2^PA_BITS-1 (0xF_FFFF_FFFF for 36). A legal address raises phys_valid, perm_rd and perm_wr and returns address bits PA_BITS-1:0 on phys_addr; it is never mapped. An illegal one is bad, with phys_addr zero and the three flags clear.
- R4: Any other address below 0xFFFF_FFFF_7FFF_FFFF gets code 3 (kernel mapped). It is mapped if the kernel enable is set and the address is below (0xFFFF_FFFF_7FFF_FFFF & M). In every other case it is bad.
- R5: Every address from 0xFFFF_FFFF_7FFF_FFFF upward gets code 4 (compatibility), with mapped, bad and phys_valid all clear.
- R6: Each address gets exactly one code from 0 to 4, and mapped and bad are never both asserted.
- R7: With REG_OUT=1 the verdict for an input appears one clock edge after it is presented. In reset the outputs hold code 4 with all flags and phys_addr zero. With REG_OUT=0 the verdict follows the inputs in the same cycle.
- R8: Each enable affects only its own segments: the user enable affects code 0, the supervisor enable affects code 1, and the kernel enable affects codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| va | input | 64 | Virtual address to classify |
| ux_en | input | 1 | User extended-space enable |
| sx_en | input | 1 | Supervisor extended-space enable |
| kx_en | input | 1 | Kernel extended-space enable |
| seg_code | output | 3 | Segment code 0..4 |
| go_mapped | output | 1 | Address is legal and needs TLB translation |
| addr_bad | output | 1 | Address is illegal for its segment |
| phys_valid | output | 1 | Legal physical-window access |
| phys_addr | output | PA_BITS | Physical address for the window |
| perm_rd | output | 1 | Read granted (physical window) |
| perm_wr | output | 1 | Write granted (physical window) |

## Verification
A wrong mask or a wrong segment limit shows only at the address values next to that limit. The bench therefore drives the value just below each limit and the limit itself, for both 40-bit and 42-bit widths and with every combination of the three enables. If an internal verdict is wrong, the ports show it after one clock edge in the registered build and in the same cycle in the combinational build. A register that samples too early or holds its value too long is found by comparing the two builds in the cycle between a change of input and the next edge.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

    typedef enum logic [2:0] {
        SEG_USER   = 3'd0,
        SEG_SUPV   = 3'd1,
        SEG_KPHYS  = 3'd2,
        SEG_KMAP   = 3'd3,
        SEG_COMPAT = 3'd4
    } seg_e;

    typedef struct packed {
        seg_e seg;
        logic mapped;
        logic bad;
        logic win_ok;
    } verdict_t;

    localparam logic [63:0] USER_TOP  = 64'h3FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SUPV_TOP  = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] KPHYS_TOP = 64'hBFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] KMAP_TOP  = 64'hFFFF_FFFF_7FFF_FFFF;
    localparam logic [63:0] KPHYS_OFS = 64'h07FF_FFFF_FFFF_FFFF;

    function automatic logic [63:0] seg_mask(input int unsigned width);
        return {2'b11, 62'd0} | ((64'd1 << width) - 64'd1);
    endfunction

endpackage

// File: rtl/vaseg_region_decode.sv
module vaseg_region_decode
    import vaseg_pkg::*;
(
    input  logic [63:0] va,
    output seg_e        region
);

    always_comb begin
        if (va < USER_TOP) begin
            region = SEG_USER;
        end else if (va < SUPV_TOP) begin
            region = SEG_SUPV;
        end else if (va < KPHYS_TOP) begin
            region = SEG_KPHYS;
        end else if (va < KMAP_TOP) begin
            region = SEG_KMAP;
        end else begin
            region = SEG_COMPAT;
        end
    end

endmodule

// File: rtl/vaseg_limit_check.sv
module vaseg_limit_check
    import vaseg_pkg::*;
#(
    parameter int unsigned SEG_BITS = 40,
    parameter int unsigned PA_BITS  = 36
) (
    input  logic [63:0]        va,
    input  seg_e               region,
    input  logic               ux_en,
    input  logic               sx_en,
    input  logic               kx_en,
    output verdict_t           verdict,
    output logic [PA_BITS-1:0] phys
);

    localparam logic [63:0] MASK      = seg_mask(SEG_BITS);
    localparam logic [63:0] USER_LIM  = USER_TOP & MASK;
    localparam logic [63:0] SUPV_LIM  = SUPV_TOP & MASK;
    localparam logic [63:0] KMAP_LIM  = KMAP_TOP & MASK;
    localparam logic [63:0] PHYS_LIM  = (64'd1 << PA_BITS) - 64'd1;

    logic user_ok;
    logic supv_ok;
    logic kphys_ok;
    logic kmap_ok;

    always_comb begin
        user_ok  = ux_en && (va < USER_LIM);
        supv_ok  = sx_en && (va < SUPV_LIM);
        kphys_ok = kx_en && ((va & KPHYS_OFS) < PHYS_LIM);
        kmap_ok  = kx_en && (va < KMAP_LIM);
    end

    always_comb begin
        verdict.seg    = region;
        verdict.mapped = 1'b0;
        verdict.bad    = 1'b0;
        verdict.win_ok = 1'b0;
        unique case (region)
            SEG_USER: begin
                verdict.mapped = user_ok;
                verdict.bad    = !user_ok;
            end
            SEG_SUPV: begin
                verdict.mapped = supv_ok;
                verdict.bad    = !supv_ok;
            end
            SEG_KPHYS: begin
                verdict.win_ok = kphys_ok;
                verdict.bad    = !kphys_ok;
            end
            SEG_KMAP: begin
                verdict.mapped = kmap_ok;
                verdict.bad    = !kmap_ok;
            end
            SEG_COMPAT: begin
                verdict.mapped = 1'b0;
            end
            default: begin
                verdict.seg = SEG_COMPAT;
            end
        endcase
        phys = verdict.win_ok ? va[PA_BITS-1:0] : '0;
    end

endmodule

// File: rtl/vaseg_out_stage.sv
module vaseg_out_stage
    import vaseg_pkg::*;
#(
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned PA_BITS = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  verdict_t           d_verdict,
    input  logic [PA_BITS-1:0] d_phys,
    output verdict_t           q_verdict,
    output logic [PA_BITS-1:0] q_phys
);

    localparam verdict_t IDLE_VERDICT = '{seg: SEG_COMPAT, mapped: 1'b0,
                                          bad: 1'b0, win_ok: 1'b0};

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_verdict <= IDLE_VERDICT;
                    q_phys    <= '0;
                end else begin
                    q_verdict <= d_verdict;
                    q_phys    <= d_phys;
                end
            end
        end else begin : g_comb
            always_comb begin
                q_verdict = d_verdict;
                q_phys    = d_phys;
            end
        end
    endgenerate

endmodule

// File: rtl/vaseg_classifier.sv
module vaseg_classifier
    import vaseg_pkg::*;
#(
    parameter int unsigned SEG_BITS = 40,
    parameter int unsigned PA_BITS  = 36,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        va,
    input  logic               ux_en,
    input  logic               sx_en,
    input  logic               kx_en,
    output logic [2:0]         seg_code,
    output logic               go_mapped,
    output logic               addr_bad,
    output logic               phys_valid,
    output logic [PA_BITS-1:0] phys_addr,
    output logic               perm_rd,
    output logic               perm_wr
);

    seg_e               region;
    verdict_t           verdict_c;
    verdict_t           verdict_q;
    logic [PA_BITS-1:0] phys_c;

    vaseg_region_decode u_decode (
        .va     (va),
        .region (region)
    );

    vaseg_limit_check #(
        .SEG_BITS (SEG_BITS),
        .PA_BITS  (PA_BITS)
    ) u_limit (
        .va      (va),
        .region  (region),
        .ux_en   (ux_en),
        .sx_en   (sx_en),
        .kx_en   (kx_en),
        .verdict (verdict_c),
        .phys    (phys_c)
    );

    vaseg_out_stage #(
        .REG_OUT (REG_OUT),
        .PA_BITS (PA_BITS)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_verdict (verdict_c),
        .d_phys    (phys_c),
        .q_verdict (verdict_q),
        .q_phys    (phys_addr)
    );

    always_comb begin
        seg_code   = verdict_q.seg;
        go_mapped  = verdict_q.mapped;
        addr_bad   = verdict_q.bad;
        phys_valid = verdict_q.win_ok;
        perm_rd    = verdict_q.win_ok;
        perm_wr    = verdict_q.win_ok;
    end

    // Port-level checks on the combined outputs
    assert_mapped_bad_exclusive_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(go_mapped && addr_bad));

    assert_code_in_range_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        seg_code <= 3'd4);

    assert_window_grant_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        phys_valid |-> (seg_code == 3'd2) && perm_rd && perm_wr && !go_mapped);

    assert_compat_quiet_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (seg_code == 3'd4) |-> (!go_mapped && !addr_bad && !phys_valid));

    generate
        if (REG_OUT) begin : g_seq_chk
            assert_user_disabled_bad_R1: assert property (
                @(posedge clk) disable iff (!rst_n)
                ((va < USER_TOP) && !ux_en) |=> (addr_bad && seg_code == 3'd0));

            assert_kmap_disabled_bad_R4: assert property (
                @(posedge clk) disable iff (!rst_n)
                ((va >= KPHYS_TOP) && (va < KMAP_TOP) && !kx_en) |=> addr_bad);

            assert_latency_follow_R7: assert property (
                @(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (region == SEG_COMPAT)) |=> (seg_code == 3'd4));
        end else begin : g_comb_chk
            assert_user_disabled_bad_R1: assert property (
                @(posedge clk) disable iff (!rst_n)
                ((va < USER_TOP) && !ux_en) |-> (addr_bad && seg_code == 3'd0));

            assert_kmap_disabled_bad_R4: assert property (
                @(posedge clk) disable iff (!rst_n)
                ((va >= KPHYS_TOP) && (va < KMAP_TOP) && !kx_en) |-> addr_bad);
        end
    endgenerate

endmodule

// File: tb/vaseg_classifier_bench.sv
`timescale 1ns/1ps
module vaseg_classifier_bench;

    localparam int PA = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   va = 64'd0;
    logic          ux_en = 1'b0;
    logic          sx_en = 1'b0;
    logic          kx_en = 1'b0;

    logic [2:0]    seg_a, seg_b;
    logic          map_a, map_b, bad_a, bad_b, pv_a, pv_b;
    logic          rd_a, rd_b, wr_a, wr_b;
    logic [PA-1:0] pa_a, pa_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    // 40-bit width, registered output
    vaseg_classifier #(.SEG_BITS(40), .PA_BITS(PA), .REG_OUT(1'b1)) u_vaseg_classifier (
        .clk(clk), .rst_n(rst_n), .va(va), .ux_en(ux_en), .sx_en(sx_en), .kx_en(kx_en),
        .seg_code(seg_a), .go_mapped(map_a), .addr_bad(bad_a), .phys_valid(pv_a),
        .phys_addr(pa_a), .perm_rd(rd_a), .perm_wr(wr_a));

    // 42-bit width, combinational output
    vaseg_classifier #(.SEG_BITS(42), .PA_BITS(PA), .REG_OUT(1'b0)) u_vaseg_classifier_w42 (
        .clk(clk), .rst_n(rst_n), .va(va), .ux_en(ux_en), .sx_en(sx_en), .kx_en(kx_en),
        .seg_code(seg_b), .go_mapped(map_b), .addr_bad(bad_b), .phys_valid(pv_b),
        .phys_addr(pa_b), .perm_rd(rd_b), .perm_wr(wr_b));

    // Expected packed result {code, mapped, bad, pv, rd, wr, phys}
    function automatic logic [43:0] model(input logic [63:0] a, input int sb,
                                          input logic ux, input logic sx, input logic kx);
        logic [63:0] m;
        logic [2:0]  c;
        logic        mp, bd, pv;
        logic [35:0] ph;
        m  = (64'h3 << 62) | ((64'd1 << sb) - 64'd1);
        mp = 1'b0; bd = 1'b0; pv = 1'b0; ph = 36'd0;
        if (a < 64'h3FFF_FFFF_FFFF_FFFF) begin
            c = 3'd0; mp = ux && (a < (64'h3FFF_FFFF_FFFF_FFFF & m)); bd = !mp;
        end else if (a < 64'h7FFF_FFFF_FFFF_FFFF) begin
            c = 3'd1; mp = sx && (a < (64'h7FFF_FFFF_FFFF_FFFF & m)); bd = !mp;
        end else if (a < 64'hBFFF_FFFF_FFFF_FFFF) begin
            c = 3'd2; pv = kx && ({5'd0, a[58:0]} < 64'h0F_FFFF_FFFF); bd = !pv;
            ph = pv ? a[35:0] : 36'd0;
        end else if (a < 64'hFFFF_FFFF_7FFF_FFFF) begin
            c = 3'd3; mp = kx && (a < (64'hFFFF_FFFF_7FFF_FFFF & m)); bd = !mp;
        end else begin
            c = 3'd4;
        end
        return {c, mp, bd, pv, pv, pv, ph};
    endfunction

    function automatic logic [63:0] probe(input int k, input int sb);
        logic [63:0] m;
        m = (64'h3 << 62) | ((64'd1 << sb) - 64'd1);
        case (k)
            0:  return 64'd0;
            1:  return 64'd1;
            2:  return (64'h3FFF_FFFF_FFFF_FFFF & m) - 64'd1;
            3:  return (64'h3FFF_FFFF_FFFF_FFFF & m);
            4:  return 64'h3FFF_FFFF_FFFF_FFFE;
            5:  return 64'h3FFF_FFFF_FFFF_FFFF;
            6:  return (64'h7FFF_FFFF_FFFF_FFFF & m) - 64'd1;
            7:  return (64'h7FFF_FFFF_FFFF_FFFF & m);
            8:  return 64'h7FFF_FFFF_FFFF_FFFE;
            9:  return 64'h7FFF_FFFF_FFFF_FFFF;
            10: return 64'h8000_0000_0000_0000;
            11: return 64'h8000_000F_FFFF_FFFE;
            12: return 64'h8000_000F_FFFF_FFFF;
            13: return 64'hB800_0001_2345_6789;
            14: return 64'h8400_0000_0000_0000;
            15: return 64'hBFFF_FFFF_FFFF_FFFE;
            16: return 64'hBFFF_FFFF_FFFF_FFFF;
            17: return (64'hFFFF_FFFF_7FFF_FFFF & m) - 64'd1;
            18: return (64'hFFFF_FFFF_7FFF_FFFF & m);
            19: return 64'hFFFF_FFFF_7FFF_FFFE;
            20: return 64'hFFFF_FFFF_7FFF_FFFF;
            21: return 64'hFFFF_FFFF_FFFF_FFFF;
            default: return 64'hC000_0000_0000_1000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1/R8";
            3'd1: return "R2/R8";
            3'd2: return "R3/R8";
            3'd3: return "R4/R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [43:0] act, input logic [43:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s va=%h ux/sx/kx=%b%b%b actual=%h expected=%h",
                     tag, va, ux_en, sx_en, kx_en, act, exp);
        end
    endtask

    function automatic logic [43:0] got_a();
        return {seg_a, map_a, bad_a, pv_a, rd_a, wr_a, pa_a};
    endfunction
    function automatic logic [43:0] got_b();
        return {seg_b, map_b, bad_b, pv_b, rd_b, wr_b, pa_b};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [43:0] ex;
        // R7: reset state of the registered build
        va = 64'h0000_0000_0000_1000; ux_en = 1'b1; sx_en = 1'b1; kx_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset", got_a(), {3'd4, 5'b00000, 36'd0});
        @(negedge clk);
        rst_n = 1'b1;

        // Boundary sweep: both widths' probe sets, every enable combination
        for (int sb = 40; sb <= 42; sb += 2) begin
            for (int k = 0; k < 23; k++) begin
                for (int e = 0; e < 8; e++) begin
                    @(negedge clk);
                    va = probe(k, sb);
                    ux_en = e[0]; sx_en = e[1]; kx_en = e[2];
                    @(posedge clk);
                    #1;
                    ex = model(va, 40, ux_en, sx_en, kx_en);
                    check(tag_of(ex[43:41]), got_a(), ex);
                    ex = model(va, 42, ux_en, sx_en, kx_en);
                    check(tag_of(ex[43:41]), got_b(), ex);
                    n_checks++;
                    if ((map_a && bad_a) || (map_b && bad_b) || seg_a > 3'd4 || seg_b > 3'd4) begin
                        n_fail++;
                        $display("FAIL R6 exclusive flags actual=%b%b/%b%b expected=no pair",
                                 map_a, bad_a, map_b, bad_b);
                    end
                end
            end
        end

        // R7: latency of registered build against same-cycle combinational build
        @(negedge clk);
        va = 64'h0000_0000_0000_2000; ux_en = 1'b1; sx_en = 1'b0; kx_en = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        va = 64'h8000_0000_1234_5678; kx_en = 1'b1;
        #1;
        check("R7 comb same cycle", got_b(), model(va, 42, 1'b1, 1'b0, 1'b1));
        check("R7 reg holds old", got_a(), model(64'h0000_0000_0000_2000, 40, 1'b1, 1'b0, 1'b0));
        @(posedge clk);
        #1;
        check("R7 reg after edge", got_a(), model(va, 40, 1'b1, 1'b0, 1'b1));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule